// File: doc/BRIEF.md
# Two-Channel DAC Conversion Sequencer

This block is the digital timing core in front of a two-channel 12-bit converter. It keeps one data register for each channel and takes writes either per channel or to both channels at once through a combined port. It derives a slow conversion tick from the input clock through a power-of-two divider. It waits for the reference to settle before the first conversion is allowed, and it steps each channel through its conversions. The analog side sees only abstract enables, a convert strobe and the latched code.

A conversion starts on a data write, or on a one-cycle event pulse when event triggering is selected for the channel. Three operating modes trade power against output stability. Continuous mode keeps the core running. Sample-hold mode switches the core off after each conversion and can refresh the held value on a timer. Sample-off mode shuts everything down between samples and tristates the output, so it warms up again before every conversion. Each completed conversion sets a sticky flag, emits a one-cycle pulse and raises a DMA request that the next data write withdraws.

Top module: `dac_timing_ctrl`

## Requirements
- R1: The conversion tick occurs once every 2^`presc` input clock cycles, and a conversion lasts two ticks. With `presc`=0 and the reference settled, a data write captured at clock edge E0 gives `done_pulse` high in the cycle after edge E3.
- R2: Writing `wr_ch[i]` loads `wdata[11:0]` into channel i and starts a conversion there. `wr_comb` loads `wdata[11:0]` into channel 0 and `wdata[23:12]` into channel 1 and starts conversions on every enabled channel only. A disabled channel takes the data but does not convert. `code0` and `code1` hold the last code converted.
- R3: When `presc_rst_ch0` is 1, a channel 0 trigger restarts the divider. The done pulse then follows the trigger edge by exactly 2*2^`presc` cycles for `presc`>0, whatever the divider phase was.
- R4: When the first channel is enabled, the reference warms up for 5 ticks if `ref_supply`=0 (bandgap) or 1 tick if `ref_supply`=1 (supply). Triggers that arrive in that window wait for it to end.
- R5: In `mode`=2 (sample-off), every conversion is preceded by its own warm-up of the same length. `out_en` is high only while that channel is converting.
- R6: In `mode`=1 (sample-hold), `hold_en` is high and `core_en` is low between conversions. With `rfsh_en[i]` set, channel i is reconverted every 2^(3+`rfsh_sel`) ticks without raising a done flag or pulse. A data write also converts the channel.
- R7: When `evt_en[i]`=1, data writes to channel i start nothing, and an `evt_pulse[i]` pulse starts the conversion.
- R8: `data_valid[i]` goes high on a write to channel i and falls when that data is taken for conversion.
- R9: When a conversion triggered by data or an event ends, `done_flag[i]` sets, `done_pulse[i]` is high for exactly one cycle and `dma_req[i]` rises. `dma_req[i]` clears on the next write to channel i or to the combined port.
- R10: `irq` is the OR of `done_flag & irq_en`. Driving a 1 on `flag_clr[i]` for one cycle clears `done_flag[i]`.
- R11: A trigger that arrives while the same channel is busy is kept and served once that conversion ends.
- R12: `ref_supply` is sampled only while both channels are disabled. Changes while any channel is enabled have no effect on warm-up length.
- R13: In `mode`=0 (continuous), once the reference has settled, `core_en` and `out_en` stay high for every enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| presc | input | 3 | Divider exponent, tick every 2^presc cycles |
| presc_rst_ch0 | input | 1 | Restart divider on channel 0 trigger |
| mode | input | 2 | 0 continuous, 1 sample-hold, 2 sample-off |
| ref_supply | input | 1 | 1 selects supply reference, 0 bandgap |
| ch_en | input | 2 | Channel enables |
| evt_en | input | 2 | Event-pulse triggering per channel |
| evt_pulse | input | 2 | One-cycle event pulses |
| rfsh_en | input | 2 | Automatic refresh per channel |
| rfsh_sel | input | 2 | Refresh period select |
| wr_ch | input | 2 | Per-channel data write strobes |
| wr_comb | input | 1 | Combined data write strobe |
| wdata | input | 24 | Write data |
| irq_en | input | 2 | Interrupt enables |
| flag_clr | input | 2 | Write-one-to-clear for done flags |
| code0 | output | 12 | Code converted on channel 0 |
| code1 | output | 12 | Code converted on channel 1 |
| data_valid | output | 2 | Unconverted data held |
| done_flag | output | 2 | Sticky conversion-done flags |
| done_pulse | output | 2 | One-cycle done pulses |
| dma_req | output | 2 | DMA requests |
| irq | output | 1 | Interrupt request |
| core_en | output | 2 | Converter core enable |
| hold_en | output | 2 | Hold element enable |
| out_en | output | 2 | Output driver enable |
| conv_strobe | output | 2 | One-cycle convert strobe |

## Verification
The hardest case to reach from the ports is a trigger that arrives while a conversion or a warm-up is still under way. The bench reaches it by placing a second write exactly two edges after the first, and by writing in the same cycle that a channel is first enabled, so the trigger falls inside the settling window. Fixed latency under divider restart can only be shown against an arbitrary divider phase. The bench therefore repeats the same write after different idle gaps and expects the identical edge count each time. Refresh spacing is measured as the strobe-to-strobe distance once the timer has reached steady state.

// File: rtl/dac_timing_ctrl.sv
module dac_timing_ctrl #(
  parameter int DW       = 12,
  parameter int PW       = 3,
  parameter int WARM_BG  = 5,
  parameter int WARM_SUP = 1,
  parameter int RF_LOG2  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   presc,
  input  logic            presc_rst_ch0,
  input  logic [1:0]      mode,
  input  logic            ref_supply,
  input  logic [1:0]      ch_en,
  input  logic [1:0]      evt_en,
  input  logic [1:0]      evt_pulse,
  input  logic [1:0]      rfsh_en,
  input  logic [1:0]      rfsh_sel,
  input  logic [1:0]      wr_ch,
  input  logic            wr_comb,
  input  logic [2*DW-1:0] wdata,
  input  logic [1:0]      irq_en,
  input  logic [1:0]      flag_clr,
  output logic [DW-1:0]   code0,
  output logic [DW-1:0]   code1,
  output logic [1:0]      data_valid,
  output logic [1:0]      done_flag,
  output logic [1:0]      done_pulse,
  output logic [1:0]      dma_req,
  output logic            irq,
  output logic [1:0]      core_en,
  output logic [1:0]      hold_en,
  output logic [1:0]      out_en,
  output logic [1:0]      conv_strobe
);

  localparam int CW = (1 << PW) - 1;
  localparam int SW = $clog2(WARM_BG + 1) + 1;
  localparam int RW = RF_LOG2 + 4;
  localparam logic [1:0] M_HOLD = 2'd1;
  localparam logic [1:0] M_OFF  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WARM, S_CONV} st_t;

  logic          any_en, tick, ref_q, ref_rdy, sh_act, rf_due;
  logic [CW-1:0] pcnt, plim;
  logic [SW-1:0] rcnt, wlast;
  logic [RW-1:0] rtmr, rlast;
  logic [1:0]    wr_hit, trig, pend, rpend, is_rf;
  logic [1:0]    start_d, start_r, go_conv, fin;
  logic [1:0]    strobe_q, done_q, flag_q, dma_q, dv_q;
  st_t           st_q   [2];
  logic [SW-1:0] scnt   [2];
  logic [DW-1:0] dat_q  [2];
  logic [DW-1:0] code_q [2];

  assign any_en = |ch_en;
  assign plim   = CW'((1 << presc) - 1);
  assign tick   = any_en && (pcnt >= plim);
  assign wlast  = ref_q ? SW'(WARM_SUP - 1) : SW'(WARM_BG - 1);
  assign sh_act = any_en && (mode == M_HOLD);
  assign rlast  = RW'((1 << (RF_LOG2 + int'(rfsh_sel))) - 1);
  assign rf_due = sh_act && tick && (rtmr >= rlast);

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      wr_hit[i]  = wr_ch[i] | wr_comb;
      trig[i]    = ch_en[i] && (evt_en[i] ? evt_pulse[i] : wr_hit[i]);
      start_d[i] = ch_en[i] && (st_q[i] == S_IDLE) && pend[i] &&
                   ((mode == M_OFF) || ref_rdy);
      start_r[i] = ch_en[i] && (st_q[i] == S_IDLE) && !pend[i] && rpend[i] &&
                   ref_rdy && (mode == M_HOLD);
      go_conv[i] = ch_en[i] &&
                   ((((start_d[i] || start_r[i]) && (mode != M_OFF))) ||
                    ((st_q[i] == S_WARM) && tick && (scnt[i] == wlast)));
      fin[i]     = ch_en[i] && (st_q[i] == S_CONV) && tick && (scnt[i] == SW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         pcnt <= '0;
    else if (!any_en || tick || (presc_rst_ch0 && trig[0])) pcnt <= '0;
    else                                                pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      ref_rdy <= 1'b0;
      rcnt    <= '0;
    end else if (!any_en) begin
      ref_q   <= ref_supply;
      ref_rdy <= 1'b0;
      rcnt    <= '0;
    end else if (tick && !ref_rdy) begin
      if (rcnt == wlast) ref_rdy <= 1'b1;
      else               rcnt    <= rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rtmr <= '0;
    else if (!sh_act) rtmr <= '0;
    else if (tick)    rtmr <= (rtmr >= rlast) ? '0 : rtmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; rpend <= '0; is_rf <= '0; strobe_q <= '0;
      done_q <= '0; flag_q <= '0; dma_q <= '0; dv_q <= '0;
      for (int i = 0; i < 2; i++) begin
        st_q[i]   <= S_IDLE;
        scnt[i]   <= '0;
        dat_q[i]  <= '0;
        code_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!ch_en[i]) begin
          st_q[i] <= S_IDLE;
          scnt[i] <= '0;
        end else begin
          case (st_q[i])
            S_IDLE: if (start_d[i] || start_r[i]) begin
              st_q[i]   <= (mode == M_OFF) ? S_WARM : S_CONV;
              scnt[i]   <= '0;
              is_rf[i]  <= start_r[i];
              code_q[i] <= dat_q[i];
            end
            S_WARM: if (tick) begin
              if (scnt[i] == wlast) begin
                st_q[i] <= S_CONV;
                scnt[i] <= '0;
              end else scnt[i] <= scnt[i] + 1'b1;
            end
            S_CONV: if (tick) begin
              if (scnt[i] == SW'(1)) st_q[i] <= S_IDLE;
              else                   scnt[i] <= scnt[i] + 1'b1;
            end
            default: st_q[i] <= S_IDLE;
          endcase
        end

        if (!ch_en[i])       pend[i] <= 1'b0;
        else if (trig[i])    pend[i] <= 1'b1;
        else if (start_d[i]) pend[i] <= 1'b0;

        if (!ch_en[i] || !rfsh_en[i] || (mode != M_HOLD)) rpend[i] <= 1'b0;
        else if (rf_due)                                  rpend[i] <= 1'b1;
        else if (start_d[i] || start_r[i])                rpend[i] <= 1'b0;

        if (wr_hit[i]) dat_q[i] <= wr_comb ? wdata[i*DW +: DW] : wdata[DW-1:0];

        if (wr_hit[i])       dv_q[i] <= 1'b1;
        else if (start_d[i]) dv_q[i] <= 1'b0;

        strobe_q[i] <= go_conv[i];
        done_q[i]   <= fin[i] && !is_rf[i];

        if (fin[i] && !is_rf[i]) flag_q[i] <= 1'b1;
        else if (flag_clr[i])    flag_q[i] <= 1'b0;

        if (fin[i] && !is_rf[i]) dma_q[i] <= 1'b1;
        else if (wr_hit[i])      dma_q[i] <= 1'b0;
      end
    end
  end

  assign code0       = code_q[0];
  assign code1       = code_q[1];
  assign data_valid  = dv_q;
  assign done_flag   = flag_q;
  assign done_pulse  = done_q;
  assign dma_req     = dma_q;
  assign conv_strobe = strobe_q;
  assign irq         = |(flag_q & irq_en);

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      hold_en[i] = ch_en[i] && (mode == M_HOLD);
      out_en[i]  = ch_en[i] && ((mode != M_OFF) || (st_q[i] == S_CONV));
      case (mode)
        M_HOLD:  core_en[i] = (st_q[i] == S_CONV);
        M_OFF:   core_en[i] = (st_q[i] != S_IDLE);
        default: core_en[i] = ch_en[i] && ref_rdy;
      endcase
    end
  end

  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en && $past(any_en)) |-> $stable(ref_q)); // R12

  for (genvar g = 0; g < 2; g++) begin : g_ast
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[g] |=> !done_pulse[g]); // R9
    AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[g] |-> done_flag[g]); // R9
    AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[g] && !(fin[g] && !is_rf[g])) |=> !dma_req[g]); // R9
    AST_WARM_BEFORE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q[g] == S_CONV) && ($past(st_q[g]) == S_IDLE)) |-> $past(ref_rdy)); // R4
    AST_OFF_REWARMS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q[g] == S_CONV) && ($past(st_q[g]) == S_IDLE)) |-> ($past(mode) != M_OFF)); // R5
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[g] && (st_q[g] != S_IDLE)) |=> (pend[g] || !ch_en[g])); // R11
  end

endmodule

// File: tb/dac_timing_ctrl_tb_top.sv
module dac_timing_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  presc = '0;
  logic        presc_rst_ch0 = 1'b0;
  logic [1:0]  mode = '0;
  logic        ref_supply = 1'b0;
  logic [1:0]  ch_en = '0, evt_en = '0, evt_pulse = '0, rfsh_en = '0, rfsh_sel = '0;
  logic [1:0]  wr_ch = '0;
  logic        wr_comb = 1'b0;
  logic [23:0] wdata = '0;
  logic [1:0]  irq_en = '0, flag_clr = '0;
  logic [11:0] code0, code1;
  logic [1:0]  data_valid, done_flag, done_pulse, dma_req, core_en, hold_en, out_en, conv_strobe;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dac_timing_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .presc(presc), .presc_rst_ch0(presc_rst_ch0),
    .mode(mode), .ref_supply(ref_supply), .ch_en(ch_en), .evt_en(evt_en),
    .evt_pulse(evt_pulse), .rfsh_en(rfsh_en), .rfsh_sel(rfsh_sel),
    .wr_ch(wr_ch), .wr_comb(wr_comb), .wdata(wdata), .irq_en(irq_en),
    .flag_clr(flag_clr), .code0(code0), .code1(code1), .data_valid(data_valid),
    .done_flag(done_flag), .done_pulse(done_pulse), .dma_req(dma_req), .irq(irq),
    .core_en(core_en), .hold_en(hold_en), .out_en(out_en), .conv_strobe(conv_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  // drive one trigger at a negedge, count negedges until the done pulse of ch
  task automatic fire(input int ch, input logic [1:0] wr, input logic comb,
                      input logic [1:0] evp, input logic [23:0] d,
                      output int n, output int oe);
    wr_ch = wr; wr_comb = comb; evt_pulse = evp; wdata = d;
    n = 0; oe = 0;
    do begin
      @(negedge clk);
      n++;
      wr_ch = '0; wr_comb = 1'b0; evt_pulse = '0;
      if (out_en[ch]) oe++;
    end while (!done_pulse[ch] && n < 60);
  endtask

  task automatic count_done(input int k, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      wr_ch = '0; wr_comb = 1'b0; evt_pulse = '0;
      if (done_pulse[0]) c0++;
      if (done_pulse[1]) c1++;
    end
  endtask

  task automatic wait_strobe(input int ch, output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!conv_strobe[ch] && k < 200);
  endtask

  task automatic t_reset;
    chk("R9 reset done_flag", done_flag, 0);
    chk("R9 reset dma_req", dma_req, 0);
    chk("R8 reset data_valid", data_valid, 0);
    chk("R10 reset irq", irq, 0);
    chk("R5 reset out_en", out_en, 0);
  endtask

  task automatic t_warm_bandgap;
    int n, oe;
    ch_en = 2'b01;
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000123, n, oe);
    chk("R4 bandgap warm-up latency", n, 8);
    chk("R2 code0 after write", code0, 12'h123);
    chk("R9 flag set", done_flag[0], 1);
    chk("R9 dma raised", dma_req[0], 1);
    cyc(1);
    chk("R9 pulse one cycle", done_pulse[0], 0);
    chk("R13 core_en continuous", core_en[0], 1);
    chk("R13 out_en continuous", out_en[0], 1);
  endtask

  task automatic t_direct;
    int n;
    wr_ch = 2'b01; wdata = 24'h000456;
    @(negedge clk); wr_ch = '0; n = 1;
    chk("R8 data_valid after write", data_valid[0], 1);
    chk("R9 dma cleared by write", dma_req[0], 0);
    while (!done_pulse[0] && n < 60) begin @(negedge clk); n++; end
    chk("R1 latency presc 0", n, 4);
    chk("R8 data_valid after conversion", data_valid[0], 0);
    chk("R9 dma after done", dma_req[0], 1);
  endtask

  task automatic t_irq;
    irq_en = 2'b01; #1;
    chk("R10 irq with enable", irq, 1);
    irq_en = 2'b10; #1;
    chk("R10 irq masked", irq, 0);
    irq_en = 2'b01; flag_clr = 2'b01;
    @(negedge clk); flag_clr = '0;
    chk("R10 flag cleared", done_flag[0], 0);
    chk("R10 irq after clear", irq, 0);
    irq_en = '0;
  endtask

  task automatic t_pending;
    int c0, c1;
    wr_ch = 2'b01; wdata = 24'h000AAA;
    @(negedge clk); wr_ch = '0;
    @(negedge clk); wr_ch = 2'b01; wdata = 24'h000BBB;
    count_done(12, c0, c1);
    chk("R11 both triggers served", c0, 2);
    chk("R11 second code converted", code0, 12'hBBB);
  endtask

  task automatic t_comb;
    int c0, c1;
    ch_en = 2'b11; cyc(1);
    wr_comb = 1'b1; wdata = {12'hB11, 12'hA00};
    count_done(8, c0, c1);
    chk("R2 comb ch0 done", c0, 1);
    chk("R2 comb ch1 done", c1, 1);
    chk("R2 comb code0", code0, 12'hA00);
    chk("R2 comb code1", code1, 12'hB11);
    ch_en = 2'b01; cyc(1);
    wr_comb = 1'b1; wdata = {12'hC22, 12'hD33};
    count_done(8, c0, c1);
    chk("R2 comb enabled ch0 done", c0, 1);
    chk("R2 comb disabled ch1 no done", c1, 0);
    chk("R2 disabled ch1 code kept", code1, 12'hB11);
    chk("R8 disabled ch1 data_valid", data_valid[1], 1);
    chk("R2 comb code0 second", code0, 12'hD33);
  endtask

  task automatic t_event;
    int n, oe, c0, c1;
    evt_en = 2'b01;
    wr_ch = 2'b01; wdata = 24'h000777;
    count_done(10, c0, c1);
    chk("R7 write ignored as trigger", c0, 0);
    chk("R7 write still stores data", data_valid[0], 1);
    fire(0, 2'b00, 1'b0, 2'b01, 24'h0, n, oe);
    chk("R7 event pulse latency", n, 4);
    chk("R7 event converts stored code", code0, 12'h777);
    evt_en = '0;
  endtask

  task automatic t_presc;
    int n, oe;
    presc = 3'd2; presc_rst_ch0 = 1'b1; cyc(3);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000111, n, oe);
    chk("R3 fixed latency div4 phase a", n, 9);
    cyc(1);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000112, n, oe);
    chk("R3 fixed latency div4 phase b", n, 9);
    cyc(2);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000113, n, oe);
    chk("R3 fixed latency div4 phase c", n, 9);
    presc = 3'd1; cyc(1);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000114, n, oe);
    chk("R1 latency div2", n, 5);
    presc = 3'd0; presc_rst_ch0 = 1'b0; cyc(2);
  endtask

  task automatic t_sample_off;
    int n, oe;
    mode = 2'd2; cyc(2);
    chk("R5 output tristated idle", out_en[0], 0);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000222, n, oe);
    chk("R5 warm-up before sample", n, 9);
    chk("R5 out_en only while converting", oe, 2);
    cyc(2);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000223, n, oe);
    chk("R5 warm-up again next sample", n, 9);
  endtask

  task automatic t_ref_ignore;
    int n, oe;
    ref_supply = 1'b1; cyc(1);
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000333, n, oe);
    chk("R12 ref change ignored while enabled", n, 9);
    ch_en = '0; cyc(2);
    ch_en = 2'b01;
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000334, n, oe);
    chk("R5 supply warm-up sample-off", n, 5);
    mode = 2'd0; ch_en = '0; cyc(2);
    ch_en = 2'b01;
    fire(0, 2'b01, 1'b0, 2'b00, 24'h000335, n, oe);
    chk("R4 supply warm-up latency", n, 4);
    ref_supply = 1'b0; ch_en = '0; cyc(2);
  endtask

  task automatic t_hold;
    int k, n, oe, c0, c1;
    flag_clr = 2'b11; @(negedge clk); flag_clr = '0;
    mode = 2'd1; rfsh_sel = 2'd0; rfsh_en = 2'b10; ch_en = 2'b10;
    cyc(30);
    wait_strobe(1, k);
    wait_strobe(1, k);
    chk("R6 refresh period sel0", k, 8);
    cyc(3);
    chk("R6 core off between samples", core_en[1], 0);
    chk("R6 hold enabled", hold_en[1], 1);
    chk("R6 refresh raises no flag", done_flag[1], 0);
    rfsh_sel = 2'd1;
    wait_strobe(1, k);
    wait_strobe(1, k);
    chk("R6 refresh period sel1", k, 16);
    cyc(2);
    fire(1, 2'b10, 1'b0, 2'b00, 24'h000444, n, oe);
    chk("R6 data write converts in hold", n, 4);
    chk("R6 data write code", code1, 12'h444);
    rfsh_en = '0; cyc(5);
    k = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (conv_strobe[1]) k++;
    end
    chk("R6 no refresh when disabled", k, 0);
    count_done(2, c0, c1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_warm_bandgap();
    t_direct();
    t_irq();
    t_pending();
    t_comb();
    t_event();
    t_presc();
    t_sample_off();
    t_ref_ignore();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule